// File: doc/BRIEF.md
# Chroma Gain and Colour Kill Stage

This stage sits after chroma demodulation in a video decoder. It takes signed colour-difference pairs (Cb, Cr) and scales both by one gain value. It then either passes the scaled pair on, centred on code 128, or replaces it with neutral grey (128, 128). The upstream burst meter gives a per-line burst amplitude, qualified by a flag that says whether the line carried burst. A per-field strobe and a chroma-PLL trouble flag complete the inputs.

Four gain policies are available. Unity applies 1x. Automatic derives the gain from a three-line burst average. Fixed takes a programmed register value. Hold keeps the last automatic value. The colour-kill logic has three settings: qualified, forced off and forced on. In the qualified setting it switches colour off or back on only after the burst average has stayed on one side of a quarter-nominal level for several fields in a row. A PLL fault blanks colour at once.

Top module: `chroma_gain_killer`

## Requirements
- R1: After reset, out_valid is 0, out_cb and out_cr are 128, and color_on is 0. The internal burst history and average start at NOM_BURST (80), the automatic gain starts at unity (64), and the burst-level state starts as "burst good".
- R2: With gain_mode 0 (unity) the gain is 64/64. The output is the input plus 128.
- R3: A line_strobe with burst_seen=1 loads burst_amp into a three-line history. The average becomes floor((current + two previous burst-bearing lines) / 3), registered one cycle later. A line_strobe with burst_seen=0 changes nothing.
- R4: With gain_mode 1 (automatic), the gain is floor(NOM_BURST*64/average), registered one cycle after the average changes. It is limited to 32..256 (0.5x..4x), and an average of 0 gives 256.
- R5: With gain_mode 2 (fixed), the gain is fixed_gain, limited to 32..256.
- R6: With gain_mode 3 (hold), the gain is the automatic gain as it stood in the last cycle in which gain_mode was not 3. Later burst changes have no effect on it.
- R7: The scaled value is floor((x*gain + 32) / 64) + 128, saturated to 16..240. The multiply is signed, with x the signed 9-bit input.
- R8: With color_ctl 0, each field_strobe tests the average against NOM_BURST/4 (20). Colour turns off on the 4th consecutive field below that level. It turns back on on the 4th consecutive field at or above it.
- R9: With color_ctl 0, pll_unlock=1 on an input sample turns colour off for that sample.
- R10: color_ctl 1 forces colour off. color_ctl 2 or 3 forces colour on, regardless of burst level and pll_unlock.
- R11: When colour is off, out_cb and out_cr are both 128.
- R12: out_valid follows in_valid one cycle later. The data outputs and color_on change only on a valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair valid |
| in_cb | input | 9 | Signed Cb sample |
| in_cr | input | 9 | Signed Cr sample |
| line_strobe | input | 1 | One-cycle pulse: a burst measurement for a line is presented |
| burst_amp | input | 8 | Measured burst amplitude for the line |
| burst_seen | input | 1 | The line carried burst |
| field_strobe | input | 1 | One-cycle pulse per field |
| pll_unlock | input | 1 | Chroma PLL phase error excessive |
| gain_mode | input | 2 | 0 unity, 1 automatic, 2 fixed, 3 hold |
| fixed_gain | input | 9 | Fixed gain, 6 fractional bits |
| color_ctl | input | 2 | 0 qualified kill, 1 force off, 2/3 force on |
| out_valid | output | 1 | Output pair valid |
| out_cb | output | 8 | Cb, offset binary |
| out_cr | output | 8 | Cr, offset binary |
| color_on | output | 1 | Colour was passed for this output pair |

## Verification
On every cycle the assertions check the following:
- the one-cycle valid latency;
- that the output range is 16..240;
- that killed pairs are neutral grey;
- that the forced settings and the PLL-fault kill act on the next output;
- that the selected gain never leaves 0.5x..4x.

Other behaviour needs the bench's reference model and its scenarios:
- the three-line averaging with burst-free lines skipped;
- the division and the limits of the automatic gain;
- the value captured on entering hold;
- the four-field hysteresis in both directions;
- exact rounding.

// File: rtl/cgk_pkg.sv
package cgk_pkg;
  typedef enum logic [1:0] {
    GM_UNITY = 2'd0,
    GM_AUTO  = 2'd1,
    GM_FIXED = 2'd2,
    GM_HOLD  = 2'd3
  } gain_mode_e;

  typedef enum logic [1:0] {
    CK_QUAL  = 2'd0,
    CK_OFF   = 2'd1,
    CK_ON    = 2'd2,
    CK_ON_B  = 2'd3
  } color_ctl_e;

  localparam int OUT_MID = 128;
  localparam int OUT_LO  = 16;
  localparam int OUT_HI  = 240;
endpackage

// File: rtl/cgk_burst_avg.sv
module cgk_burst_avg #(
  parameter int BURST_W    = 8,
  parameter int HIST_LINES = 3,
  parameter int NOM_BURST  = 80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_strobe,
  input  logic               burst_seen,
  input  logic [BURST_W-1:0] burst_amp,
  output logic [BURST_W-1:0] avg_q
);
  localparam int SUM_W = BURST_W + $clog2(HIST_LINES) + 1;
  localparam int PREV  = HIST_LINES - 1;
  localparam logic [SUM_W-1:0] DIVISOR = SUM_W'(HIST_LINES);

  logic [BURST_W-1:0] hist_q [PREV];
  logic [SUM_W-1:0]   sum;
  logic               take;

  assign take = line_strobe && burst_seen;

  always_comb begin
    sum = SUM_W'(burst_amp);
    for (int i = 0; i < PREV; i++) begin
      sum = sum + SUM_W'(hist_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PREV; i++) hist_q[i] <= BURST_W'(NOM_BURST);
      avg_q <= BURST_W'(NOM_BURST);
    end else if (take) begin
      hist_q[0] <= burst_amp;
      for (int i = 1; i < PREV; i++) hist_q[i] <= hist_q[i-1];
      avg_q <= BURST_W'(sum / DIVISOR);
    end
  end
endmodule

// File: rtl/cgk_gain_sel.sv
module cgk_gain_sel
  import cgk_pkg::*;
#(
  parameter int BURST_W   = 8,
  parameter int GAIN_FRAC = 6,
  parameter int GAIN_W    = GAIN_FRAC + 3,
  parameter int NOM_BURST = 80
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BURST_W-1:0] avg,
  input  logic [1:0]         gain_mode,
  input  logic [GAIN_W-1:0]  fixed_gain,
  output logic [GAIN_W-1:0]  gain_cur
);
  localparam logic [31:0] G_MIN   = 32'(1) << (GAIN_FRAC - 1);
  localparam logic [31:0] G_MAX   = 32'(4) << GAIN_FRAC;
  localparam logic [31:0] G_UNITY = 32'(1) << GAIN_FRAC;
  localparam logic [31:0] NUMER   = 32'(NOM_BURST) << GAIN_FRAC;

  function automatic logic [GAIN_W-1:0] limit(input logic [31:0] v);
    if (v < G_MIN)      return GAIN_W'(G_MIN);
    else if (v > G_MAX) return GAIN_W'(G_MAX);
    else                return GAIN_W'(v);
  endfunction

  gain_mode_e         mode;
  logic [GAIN_W-1:0]  auto_next, auto_q, hold_q;

  assign mode = gain_mode_e'(gain_mode);

  always_comb begin
    if (avg == '0) auto_next = GAIN_W'(G_MAX);
    else           auto_next = limit(NUMER / 32'(avg));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_q <= GAIN_W'(G_UNITY);
      hold_q <= GAIN_W'(G_UNITY);
    end else begin
      auto_q <= auto_next;
      if (mode != GM_HOLD) hold_q <= auto_q;
    end
  end

  always_comb begin
    unique case (mode)
      GM_UNITY: gain_cur = GAIN_W'(G_UNITY);
      GM_AUTO:  gain_cur = auto_q;
      GM_FIXED: gain_cur = limit(32'(fixed_gain));
      default:  gain_cur = hold_q;
    endcase
  end
endmodule

// File: rtl/cgk_killer.sv
module cgk_killer #(
  parameter int BURST_W     = 8,
  parameter int NOM_BURST   = 80,
  parameter int KILL_FIELDS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               field_strobe,
  input  logic [BURST_W-1:0] avg,
  output logic               burst_ok
);
  localparam int CNT_W = $clog2(KILL_FIELDS + 1);
  localparam logic [CNT_W-1:0]   CNT_TOP = CNT_W'(KILL_FIELDS);
  localparam logic [CNT_W-1:0]   CNT_ARM = CNT_W'(KILL_FIELDS - 1);
  localparam logic [BURST_W-1:0] LEVEL   = BURST_W'(NOM_BURST / 4);

  logic [CNT_W-1:0] low_cnt, high_cnt;
  logic             below;

  assign below = avg < LEVEL;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      high_cnt <= '0;
      burst_ok <= 1'b1;
    end else if (field_strobe) begin
      if (below) begin
        high_cnt <= '0;
        if (low_cnt != CNT_TOP) low_cnt <= low_cnt + 1'b1;
        if (low_cnt >= CNT_ARM) burst_ok <= 1'b0;
      end else begin
        low_cnt <= '0;
        if (high_cnt != CNT_TOP) high_cnt <= high_cnt + 1'b1;
        if (high_cnt >= CNT_ARM) burst_ok <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cgk_scale.sv
module cgk_scale
  import cgk_pkg::*;
#(
  parameter int DATA_W    = 9,
  parameter int GAIN_FRAC = 6,
  parameter int GAIN_W    = GAIN_FRAC + 3
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [GAIN_W-1:0] gain,
  output logic        [7:0]        scaled
);
  localparam int P_W  = DATA_W + GAIN_W + 2;
  localparam int HALF = 1 << (GAIN_FRAC - 1);

  logic signed [P_W-1:0] prod, rnd, val;

  always_comb begin
    prod = P_W'(sample) * P_W'($signed({1'b0, gain}));
    rnd  = (prod + P_W'(HALF)) >>> GAIN_FRAC;
    val  = rnd + P_W'(OUT_MID);
    if (val < P_W'(OUT_LO))      scaled = 8'(OUT_LO);
    else if (val > P_W'(OUT_HI)) scaled = 8'(OUT_HI);
    else                         scaled = val[7:0];
  end
endmodule

// File: rtl/chroma_gain_killer.sv
module chroma_gain_killer
  import cgk_pkg::*;
#(
  parameter int DATA_W      = 9,
  parameter int BURST_W     = 8,
  parameter int GAIN_FRAC   = 6,
  parameter int GAIN_W      = GAIN_FRAC + 3,
  parameter int NOM_BURST   = 80,
  parameter int HIST_LINES  = 3,
  parameter int KILL_FIELDS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_cb,
  input  logic signed [DATA_W-1:0] in_cr,
  input  logic                     line_strobe,
  input  logic [BURST_W-1:0]       burst_amp,
  input  logic                     burst_seen,
  input  logic                     field_strobe,
  input  logic                     pll_unlock,
  input  logic [1:0]               gain_mode,
  input  logic [GAIN_W-1:0]        fixed_gain,
  input  logic [1:0]               color_ctl,
  output logic                     out_valid,
  output logic [7:0]               out_cb,
  output logic [7:0]               out_cr,
  output logic                     color_on
);
  logic [BURST_W-1:0] avg_q;
  logic [GAIN_W-1:0]  gain_cur;
  logic               burst_ok, color_now;
  logic [7:0]         scaled [2];
  logic signed [DATA_W-1:0] chan_in [2];
  color_ctl_e         ctl;

  assign ctl        = color_ctl_e'(color_ctl);
  assign chan_in[0] = in_cb;
  assign chan_in[1] = in_cr;

  cgk_burst_avg #(.BURST_W(BURST_W), .HIST_LINES(HIST_LINES), .NOM_BURST(NOM_BURST)) u_avg (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .burst_seen(burst_seen),
    .burst_amp(burst_amp), .avg_q(avg_q));

  cgk_gain_sel #(.BURST_W(BURST_W), .GAIN_FRAC(GAIN_FRAC), .GAIN_W(GAIN_W),
                 .NOM_BURST(NOM_BURST)) u_gain (
    .clk(clk), .rst(rst), .avg(avg_q), .gain_mode(gain_mode),
    .fixed_gain(fixed_gain), .gain_cur(gain_cur));

  cgk_killer #(.BURST_W(BURST_W), .NOM_BURST(NOM_BURST), .KILL_FIELDS(KILL_FIELDS)) u_kill (
    .clk(clk), .rst(rst), .field_strobe(field_strobe), .avg(avg_q), .burst_ok(burst_ok));

  for (genvar c = 0; c < 2; c++) begin : g_chan
    cgk_scale #(.DATA_W(DATA_W), .GAIN_FRAC(GAIN_FRAC), .GAIN_W(GAIN_W)) u_scale (
      .sample(chan_in[c]), .gain(gain_cur), .scaled(scaled[c]));
  end

  always_comb begin
    unique case (ctl)
      CK_QUAL: color_now = burst_ok && !pll_unlock;
      CK_OFF:  color_now = 1'b0;
      default: color_now = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_cb    <= 8'(OUT_MID);
      out_cr    <= 8'(OUT_MID);
      color_on  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        color_on <= color_now;
        out_cb   <= color_now ? scaled[0] : 8'(OUT_MID);
        out_cr   <= color_now ? scaled[1] : 8'(OUT_MID);
      end
    end
  end
endmodule

// File: rtl/cgk_checker.sv
module cgk_checker #(
  parameter int GAIN_FRAC = 6,
  parameter int GAIN_W    = GAIN_FRAC + 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        color_ctl,
  input logic              pll_unlock,
  input logic              out_valid,
  input logic [7:0]        out_cb,
  input logic [7:0]        out_cr,
  input logic              color_on,
  input logic [GAIN_W-1:0] gain_cur
);
  localparam logic [GAIN_W-1:0] G_MIN = GAIN_W'(1 << (GAIN_FRAC - 1));
  localparam logic [GAIN_W-1:0] G_MAX = GAIN_W'(4 << GAIN_FRAC);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R12
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R12
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_cb) && $stable(out_cr) && $stable(color_on)); // R12
  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cb >= 8'd16 && out_cb <= 8'd240 && out_cr >= 8'd16 && out_cr <= 8'd240)); // R7
  AST_KILL_GREY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !color_on) |-> (out_cb == 8'd128 && out_cr == 8'd128)); // R11
  AST_FORCE_OFF: assert property (@(posedge clk) disable iff (rst)
    (in_valid && color_ctl == 2'd1) |=> !color_on); // R10
  AST_FORCE_ON: assert property (@(posedge clk) disable iff (rst)
    (in_valid && color_ctl[1]) |=> color_on); // R10
  AST_PLL_KILL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && color_ctl == 2'd0 && pll_unlock) |=> !color_on); // R9
  AST_GAIN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    (gain_cur >= G_MIN && gain_cur <= G_MAX)); // R4
endmodule

bind chroma_gain_killer cgk_checker #(.GAIN_FRAC(GAIN_FRAC), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .color_ctl(color_ctl),
  .pll_unlock(pll_unlock), .out_valid(out_valid), .out_cb(out_cb), .out_cr(out_cr),
  .color_on(color_on), .gain_cur(gain_cur));

// File: tb/test_chroma_gain_killer.sv
`timescale 1ns/1ps
module test_chroma_gain_killer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [8:0] in_cb = '0, in_cr = '0;
  logic line_strobe = 1'b0, burst_seen = 1'b0, field_strobe = 1'b0, pll_unlock = 1'b0;
  logic [7:0] burst_amp = '0;
  logic [1:0] gain_mode = 2'd0, color_ctl = 2'd0;
  logic [8:0] fixed_gain = 9'd64;
  logic out_valid, color_on;
  logic [7:0] out_cb, out_cr;

  always #2.5 clk = ~clk;

  chroma_gain_killer i_chroma_gain_killer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cb(in_cb), .in_cr(in_cr),
    .line_strobe(line_strobe), .burst_amp(burst_amp), .burst_seen(burst_seen),
    .field_strobe(field_strobe), .pll_unlock(pll_unlock), .gain_mode(gain_mode),
    .fixed_gain(fixed_gain), .color_ctl(color_ctl), .out_valid(out_valid),
    .out_cb(out_cb), .out_cr(out_cr), .color_on(color_on));

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model state
  int m_h1, m_h2, m_avg, m_auto, m_frz, m_lo, m_hi;
  bit m_ok;
  int e_cb = 128, e_cr = 128;
  bit e_valid = 0, e_on = 0;
  int g, t_avg, t_auto, t_frz;
  bit on;

  function automatic int limg(int v);
    if (v < 32) return 32;
    if (v > 256) return 256;
    return v;
  endfunction

  function automatic int scale(int x, int gg);
    int r;
    r = (x * gg + 32) >>> 6;
    r = r + 128;
    if (r < 16) r = 16;
    if (r > 240) r = 240;
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_h1 = 80; m_h2 = 80; m_avg = 80; m_auto = 64; m_frz = 64;
      m_lo = 0; m_hi = 0; m_ok = 1;
      e_valid = 0; e_cb = 128; e_cr = 128; e_on = 0;
    end else begin
      case (gain_mode)
        2'd0: g = 64;
        2'd1: g = m_auto;
        2'd2: g = limg(int'(fixed_gain));
        default: g = m_frz;
      endcase
      if (color_ctl == 2'd1) on = 0;
      else if (color_ctl[1]) on = 1;
      else on = m_ok && !pll_unlock;
      e_valid = in_valid;
      if (in_valid) begin
        e_on = on;
        e_cb = on ? scale(int'(in_cb), g) : 128;
        e_cr = on ? scale(int'(in_cr), g) : 128;
      end
      t_auto = (m_avg == 0) ? 256 : limg((80 * 64) / m_avg);
      t_frz  = (gain_mode != 2'd3) ? m_auto : m_frz;
      if (field_strobe) begin
        if (m_avg < 20) begin
          m_hi = 0; if (m_lo < 4) m_lo++; if (m_lo >= 4) m_ok = 0;
        end else begin
          m_lo = 0; if (m_hi < 4) m_hi++; if (m_hi >= 4) m_ok = 1;
        end
      end
      t_avg = m_avg;
      if (line_strobe && burst_seen) begin
        t_avg = (int'(burst_amp) + m_h1 + m_h2) / 3;
        m_h2 = m_h1; m_h1 = int'(burst_amp);
      end
      m_avg = t_avg; m_auto = t_auto; m_frz = t_frz;
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, "out_valid", int'(out_valid), int'(e_valid));
      if (e_valid) begin
        chk(cur_req, "out_cb", int'(out_cb), e_cb);
        chk(cur_req, "out_cr", int'(out_cr), e_cr);
        chk(cur_req, "color_on", int'(color_on), int'(e_on));
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int cb, int cr);
    @(negedge clk);
    in_valid = 1; in_cb = 9'(cb); in_cr = 9'(cr);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic line(int amp, bit present);
    @(negedge clk);
    line_strobe = 1; burst_amp = 8'(amp); burst_seen = present;
    @(negedge clk);
    line_strobe = 0; burst_seen = 0;
  endtask

  task automatic field();
    @(negedge clk);
    field_strobe = 1;
    @(negedge clk);
    field_strobe = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: cycles=20000 expected completion earlier");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state seen at the ports
    chk("R1", "out_valid", int'(out_valid), 0);
    chk("R1", "out_cb", int'(out_cb), 128);
    chk("R1", "out_cr", int'(out_cr), 128);
    chk("R1", "color_on", int'(color_on), 0);
    rst = 0;

    // R2 unity gain and R7 clamping
    cur_req = "R2";
    send(50, -60);
    chk("R2", "unity cb", int'(out_cb), 178);
    send(0, 1);
    cur_req = "R7";
    send(200, -200);
    chk("R7", "clamp high", int'(out_cb), 240);
    chk("R7", "clamp low", int'(out_cr), 16);
    send(-113, 112);

    // R3/R4 automatic gain from the burst average
    cur_req = "R3";
    gain_mode = 2'd1;
    line(40, 1);
    line(200, 0);
    line(40, 1);
    idle(2);
    send(64, -7);
    chk("R3", "auto avg 53 gain 96 cb", int'(out_cb), 224);
    cur_req = "R4";
    line(10, 1); line(10, 1); line(10, 1);
    idle(2);
    send(20, -20);
    chk("R4", "gain limited to 4x cb", int'(out_cb), 208);
    line(200, 1); line(200, 1); line(200, 1);
    idle(2);
    send(100, -33);
    chk("R4", "gain limited to 0.5x cb", int'(out_cb), 178);
    line(0, 1); line(0, 1); line(0, 1);
    idle(2);
    send(10, 3);
    chk("R4", "zero average gives 4x cb", int'(out_cb), 168);
    line(80, 1); line(80, 1); line(60, 1);
    idle(2);
    send(37, -91);

    // R5 fixed gain
    cur_req = "R5";
    gain_mode = 2'd2;
    fixed_gain = 9'd10;  send(64, -64);
    chk("R5", "fixed low limit cb", int'(out_cb), 160);
    fixed_gain = 9'd400; send(16, -16);
    chk("R5", "fixed high limit cb", int'(out_cb), 192);
    fixed_gain = 9'd100; send(33, -45);

    // R6 hold keeps the gain captured on entry
    cur_req = "R6";
    gain_mode = 2'd1;
    line(40, 1); line(40, 1); line(40, 1);
    idle(3);
    send(32, 32);
    chk("R6", "auto before hold cb", int'(out_cb), 192);
    gain_mode = 2'd3;
    line(200, 1); line(200, 1); line(200, 1);
    idle(3);
    send(32, -32);
    chk("R6", "hold ignores burst cb", int'(out_cb), 192);
    gain_mode = 2'd0;

    // R8 four-field hysteresis, R11 grey when killed
    cur_req = "R8";
    line(10, 1); line(10, 1); line(10, 1);
    idle(2);
    field(); field(); field();
    send(40, 40);
    chk("R8", "still on after 3 low fields", int'(color_on), 1);
    field();
    send(40, -40);
    chk("R8", "off after 4 low fields", int'(color_on), 0);
    chk("R11", "killed cb", int'(out_cb), 128);
    cur_req = "R11";
    send(-90, 90);
    cur_req = "R8";
    line(80, 1); line(80, 1); line(80, 1);
    idle(2);
    field(); field(); field();
    send(5, 5);
    chk("R8", "still off after 3 good fields", int'(color_on), 0);
    field(); field(); field();
    field(); field(); field(); field();
    line(10, 1); line(10, 1); line(10, 1);
    idle(2);
    field(); field(); field();
    line(80, 1); idle(1); field();
    send(5, 5);
    chk("R8", "run broken stays on", int'(color_on), 1);

    // R9 PLL fault, R10 forced settings
    cur_req = "R9";
    line(80, 1); line(80, 1); line(80, 1);
    idle(2);
    field(); field(); field(); field();
    pll_unlock = 1;
    send(70, 70);
    chk("R9", "pll kill", int'(color_on), 0);
    cur_req = "R10";
    color_ctl = 2'd2;
    send(70, -70);
    chk("R10", "force on through pll fault", int'(out_cb), 198);
    pll_unlock = 0;
    color_ctl = 2'd1;
    send(70, -70);
    chk("R10", "force off cb", int'(out_cb), 128);
    color_ctl = 2'd3;
    line(5, 1); line(5, 1); line(5, 1); idle(2);
    field(); field(); field(); field(); field();
    send(-20, 20);
    chk("R10", "force on with low burst", int'(color_on), 1);
    color_ctl = 2'd0;
    send(-20, 20);
    chk("R8", "qualified off after low fields", int'(color_on), 0);

    // R12 latency with back-to-back samples
    cur_req = "R12";
    color_ctl = 2'd2;
    @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      in_valid = (i % 3) != 1; in_cb = 9'(i * 7 - 60); in_cr = 9'(50 - i * 5);
      @(negedge clk);
    end
    in_valid = 0;
    idle(3);
    finish_run();
  end
endmodule